// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM. That RAM has an active-low chip select, an active-low write strobe and an active-low output enable. Requests arrive one at a time over a valid/ready handshake. Each request carries a read/write flag, a 15-bit address and 8-bit write data. A read returns its data together with a one-cycle response pulse. A write returns nothing.

The controller drives the memory's address lines and its three strobes. It also drives the shared 8-bit data bus through a separate output value, an output enable and an input value, so the pad tri-state buffer can sit outside the block. Each phase of a memory cycle is held for a whole number of clock cycles. These counts are computed when the design is elaborated, from nanosecond limits and a clock-period parameter. Either memory speed grade can therefore be met by changing parameters alone.

Back-pressure rules:
- `req_ready` is high only while no memory cycle is in progress.
- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- A requester may hold `req_valid` high while `req_ready` is low. Nothing is taken in those cycles, and the request inputs may change freely.
- The response side has no ready signal. The consumer must accept `rsp_valid` in the cycle it is high.

Top module: `sram_ctl`

## Requirements
- R1: While `rst` (synchronous, active high) is high, and on the first edge after it is sampled high, `mem_ce_n`, `mem_we_n` and `mem_oe_n` go to 1 and `mem_dq_oe` goes to 0. After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 0 in every cycle where `mem_ce_n` is 0, so exactly one request is taken per memory cycle. Inputs held valid during a busy cycle are not taken.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly N_RD cycles, and presents the request address on `mem_addr`. N_RD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_DOE/CLK), which is 2 with the default parameters.
- R4: Read data is sampled from `mem_dq_in` at the edge that ends the N_RD window. It is presented on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle.
- R5: A write holds `mem_ce_n`=0 and `mem_oe_n`=1 throughout. It drives `mem_we_n`=0 for exactly N_PW = max(ceil(T_PWE/CLK), ceil(T_SD/CLK)) cycles, which is 1 by default. `mem_dq_oe`=1 holds in every cycle that `mem_we_n` is 0.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It rises only after `mem_oe_n` has been 1 for more than N_TA = ceil(T_HZOE/CLK) cycles, which is 1 by default.
- R7: `mem_addr`, and `mem_dq_out` at the rising edge of `mem_we_n`, equal the accepted request's address and data, even if the request inputs change during the cycle.
- R8: Every phase count is at least one cycle. The chip-select-low span of a write lasts at least ceil(T_WC/CLK) cycles, which is 2 by default.
- R9: While `mem_ce_n` is 1, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R10: Data written to an address is returned by a later read of that address, at both address extremes 0x0000 and 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable, 1 = drive |
| mem_dq_in | input | 8 | Value sensed on the data bus |

## Verification
The assertions assume that the request inputs are only sampled when `req_ready` is high. They also assume that `mem_dq_in` carries valid memory data by the edge that ends the read window. The bench's memory model therefore returns a poison value (0xA5) until the access time, counted in cycles, has elapsed. The bench drives every request at the falling edge and holds `req_valid` through busy cycles in some sequences. While it holds the valid, it puts inverted address and data on the request inputs. This keeps the stimulus inside the handshake rules while still testing that busy-time inputs are ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_WAIT  = 3'd1,
    ST_RD_CAP   = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_RECOV = 3'd5
  } ctl_state_e;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    if (clk_ns == 0) return 1;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8: a countdown never wraps below zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end

  // R7: registered request copy only moves on a hand-off
  a_r7_hold_copy: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CW    = 2,
  parameter int unsigned N_RD  = 2,
  parameter int unsigned N_TA  = 1,
  parameter int unsigned N_PW  = 1,
  parameter int unsigned N_REC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_fire,
  input  logic          req_write,
  input  logic          timer_done,
  output ctl_state_e    state_q,
  output logic          timer_load,
  output logic [CW-1:0] timer_val,
  output logic          capture,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);
  localparam logic [CW-1:0] LD_RD  = CW'(N_RD - 1);
  localparam logic [CW-1:0] LD_TA  = CW'(N_TA - 1);
  localparam logic [CW-1:0] LD_PW  = CW'(N_PW - 1);
  localparam logic [CW-1:0] LD_REC = CW'(N_REC - 1);

  ctl_state_e nxt;

  always_comb begin
    nxt        = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    case (state_q)
      ST_IDLE: if (req_fire) begin
        timer_load = 1'b1;
        if (req_write) begin nxt = ST_WR_SETUP; timer_val = LD_TA; end
        else           begin nxt = ST_RD_WAIT;  timer_val = LD_RD; end
      end
      ST_RD_WAIT:  if (timer_done) nxt = ST_RD_CAP;
      ST_RD_CAP:   nxt = ST_IDLE;
      ST_WR_SETUP: if (timer_done) begin
        nxt = ST_WR_PULSE; timer_load = 1'b1; timer_val = LD_PW;
      end
      ST_WR_PULSE: if (timer_done) begin
        nxt = ST_WR_RECOV; timer_load = 1'b1; timer_val = LD_REC;
      end
      ST_WR_RECOV: if (timer_done) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign capture = (state_q == ST_RD_WAIT) && timer_done;

  // strobes are registered from the next state: glitch-free pins
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= nxt;
      ce_n    <= !(nxt == ST_RD_WAIT || nxt == ST_WR_SETUP ||
                   nxt == ST_WR_PULSE || nxt == ST_WR_RECOV);
      oe_n    <= !(nxt == ST_RD_WAIT);
      we_n    <= !(nxt == ST_WR_PULSE);
      dq_oe   <= (nxt == ST_WR_PULSE) || (nxt == ST_WR_RECOV);
    end
  end

  // R1: reset parks every strobe
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ce_n && we_n && oe_n && !dq_oe));
  // R3: output enable only with a selected, non-writing memory
  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ce_n && we_n));
  // R5: data driven for the whole write pulse
  a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (dq_oe && oe_n && !ce_n));
  // R6: no contention, and drive starts after output enable was already high
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);
  a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(oe_n));
  // R9: deselected means quiet
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (we_n && oe_n && !dq_oe));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned T_RC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_DOE_NS  = 5,
  parameter int unsigned T_WC_NS   = 12,
  parameter int unsigned T_PWE_NS  = 8,
  parameter int unsigned T_SD_NS   = 7,
  parameter int unsigned T_HZOE_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned N_RD  = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                            ns_to_cyc(T_AA_NS, CLK_NS)),
                                       ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned N_TA  = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned N_PW  = max2(ns_to_cyc(T_PWE_NS, CLK_NS),
                                       ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_REC = (N_WC > N_PW + N_TA) ? (N_WC - N_PW - N_TA) : 1;
  localparam int unsigned N_MAX = max2(max2(N_RD, N_TA), max2(N_PW, N_REC));
  localparam int unsigned CW    = max2(1, $clog2(N_MAX));

  ctl_state_e      state_q;
  logic            req_fire;
  logic            timer_load;
  logic [CW-1:0]   timer_val;
  logic            timer_done;
  logic            capture;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign rsp_valid = (state_q == ST_RD_CAP);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  sram_seq_fsm #(
    .CW(CW), .N_RD(N_RD), .N_TA(N_TA), .N_PW(N_PW), .N_REC(N_REC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_fire   (req_fire),
    .req_write  (req_write),
    .timer_done (timer_done),
    .state_q    (state_q),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (capture),
    .ce_n       (mem_ce_n),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .dq_oe      (mem_dq_oe)
  );

  sram_io_path #(.AW(ADDR_W), .DW(DATA_W)) u_io (
    .clk      (clk),
    .rst      (rst),
    .take     (req_fire),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .capture  (capture),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rdata_q  (rsp_rdata)
  );

  // R2: never ready while the memory is selected
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);
  // R4: read response is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7: address held while the memory stays selected
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int CLK_NS = 8;

  function automatic int cdiv(input int n, input int d);
    int c;
    c = (n + d - 1) / d;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NRD_E = imax(imax(cdiv(12, CLK_NS), cdiv(12, CLK_NS)), cdiv(5, CLK_NS));
  localparam int NPW_E = imax(cdiv(8, CLK_NS), cdiv(7, CLK_NS));
  localparam int NTA_E = cdiv(5, CLK_NS);
  localparam int NWC_E = cdiv(12, CLK_NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hA5;
  logic [14:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, failures = 0;
  int n_wr_exp = 0, n_rd_exp = 0, n_wr_seen = 0, n_rd_seen = 0;

  logic [7:0]  shadow [logic [14:0]];
  logic [7:0]  mem    [logic [14:0]];
  logic [14:0] exp_wa_q[$];
  logic [7:0]  exp_wd_q[$];
  logic [14:0] exp_ra_q[$];
  logic [7:0]  exp_rd_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sh_rd(input logic [14:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction
  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // memory model: data valid only after the access time in cycles
  int rd_cnt = 0;
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      rd_cnt    <= rd_cnt + 1;
      mem_dq_in <= (rd_cnt + 1 >= NRD_E - 1) ? mem_rd(mem_addr) : 8'hA5;
    end else begin
      rd_cnt    <= 0;
      mem_dq_in <= 8'hA5;
    end
  end

  // monitor / scoreboard, sampled away from the active edge
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1, p_dqoe = 1'b0, p_rsp = 1'b0;
  logic [7:0] last_wd = '0;
  int we_lo = 0, oe_lo = 0, oe_hi = 0, ce_lo = 0;
  bit saw_wr = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(mem_ce_n && (!mem_we_n || !mem_oe_n || mem_dq_oe)), "R9 quiet while deselected",
          {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
      chk(!(mem_dq_oe && !mem_oe_n), "R6 contention", mem_oe_n, 1);
      chk(!(!mem_ce_n && req_ready), "R2 ready while busy", req_ready, 0);
      if (!mem_we_n) chk(mem_dq_oe, "R5 drive during pulse", mem_dq_oe, 1);
      if (!mem_we_n) chk(mem_oe_n, "R5 oe high in write", mem_oe_n, 1);

      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      if (mem_dq_oe && !p_dqoe) chk(oe_hi > NTA_E, "R6 turnaround", oe_hi - 1, NTA_E);

      if (!mem_we_n) begin we_lo++; last_wd = mem_dq_out; saw_wr = 1; end
      if (mem_we_n && !p_we) begin
        n_wr_seen++;
        chk(we_lo == NPW_E, "R5 we pulse width", we_lo, NPW_E);
        if (exp_wa_q.size() > 0) begin
          chk(mem_addr == exp_wa_q[0], "R7 write address", mem_addr, exp_wa_q[0]);
          chk(last_wd == exp_wd_q[0], "R7 write data", last_wd, exp_wd_q[0]);
          void'(exp_wa_q.pop_front());
          void'(exp_wd_q.pop_front());
        end else chk(0, "R2 unexpected write", mem_addr, 0);
        mem[mem_addr] = last_wd;
        we_lo = 0;
      end

      if (!mem_oe_n) oe_lo++;
      if (mem_oe_n && !p_oe) begin
        chk(oe_lo == NRD_E, "R3 read window", oe_lo, NRD_E);
        oe_lo = 0;
      end
      if (!mem_oe_n && p_oe) begin
        if (exp_ra_q.size() > 0) begin
          chk(mem_addr == exp_ra_q[0], "R3 read address", mem_addr, exp_ra_q[0]);
          void'(exp_ra_q.pop_front());
        end else chk(0, "R2 unexpected read", mem_addr, 0);
      end

      if (!mem_ce_n) ce_lo++;
      if (mem_ce_n && !p_ce) begin
        if (saw_wr) chk(ce_lo >= NWC_E, "R8 write cycle length", ce_lo, NWC_E);
        ce_lo = 0; saw_wr = 0;
      end

      if (rsp_valid) begin
        n_rd_seen++;
        chk(!p_rsp, "R4 single pulse", p_rsp, 0);
        if (exp_rd_q.size() > 0) begin
          chk(rsp_rdata == exp_rd_q[0], "R4 R10 read data", rsp_rdata, exp_rd_q[0]);
          void'(exp_rd_q.pop_front());
        end else chk(0, "R4 unexpected response", rsp_rdata, 0);
      end
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_ce = mem_ce_n; p_dqoe = mem_dq_oe; p_rsp = rsp_valid;
  end

  // driver: pushes expectations as it issues each request
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d, input bit hold);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    if (w) begin
      shadow[a] = d; exp_wa_q.push_back(a); exp_wd_q.push_back(d); n_wr_exp++;
    end else begin
      exp_ra_q.push_back(a); exp_rd_q.push_back(sh_rd(a)); n_rd_exp++;
    end
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    req_addr = ~a; req_wdata = ~d; req_write = ~w;  // R7 junk while busy
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (!(req_ready && exp_rd_q.size() == 0 && exp_wa_q.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1 ready no rsp", {req_ready, rsp_valid}, 2'b10);

    // R10 boundaries and basic patterns
    issue(1, 15'h0000, 8'h11, 0);
    issue(1, 15'h7FFF, 8'hEE, 0);
    issue(1, 15'h1234, 8'h5A, 0);
    issue(0, 15'h0000, 8'h00, 0);
    issue(0, 15'h7FFF, 8'h00, 0);
    issue(0, 15'h1234, 8'h00, 0);
    issue(0, 15'h0100, 8'h00, 0);   // unwritten: zero
    drain();

    // R2 R7 back-to-back with valid held through busy cycles
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      a = 15'((i * 1237 + 91) & 15'h7FFF);
      issue(1, a, 8'((i * 37) ^ 8'hC3), 1);
      issue(0, a, 8'h00, 1);
      if (i % 3 == 0) issue(1, a, 8'(i + 8'h40), 1);
    end
    drain();
    for (int i = 0; i < 24; i++) issue(0, 15'((i * 1237 + 91) & 15'h7FFF), 8'h00, (i % 2) == 0);
    drain();

    // R1 reset in the middle of a write
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0042; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 mid-cycle reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    issue(0, 15'h0042, 8'h00, 0);   // aborted write left memory untouched
    issue(0, 15'h7FFF, 8'h00, 0);
    drain();

    chk(n_wr_seen == n_wr_exp, "R2 write count", n_wr_seen, n_wr_exp);
    chk(n_rd_seen == n_rd_exp, "R2 read count", n_rd_seen, n_rd_exp);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule